// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and turns them into vectored calls. Three sources feed it: an external pin that is active on a falling edge, a pulse from a timer when it overflows, and a pulse from a data converter when a conversion ends. Each source latches a request flag. Software controls the block through one 8-bit register on a simple address-matched bus. The register holds a master enable, one enable for each source and the three request flags.

The core marks the cycles in which interrupts may be taken with a sampling strobe. On such a cycle the block picks the highest-priority request that is pending and enabled, provided the master enable is on and the core's call stack is not full. It then raises a one-cycle call request with the vector address, clears that flag and clears the master enable. The core reports its returns. A return-from-interrupt strobe turns the master enable back on. A plain return strobe leaves it unchanged.

Top module: `vpic_top`

## Requirements
- R1: The register at address CTRL_ADDR (default 0x20) reads back {0, adc flag, timer flag, ext flag, adc enable, timer enable, ext enable, master enable}, from bit 7 down to bit 0. A write sets all of bits 0–6, and bit 7 always reads 0. Read data is registered and reflects the state before the read cycle's clock edge. Any other address reads 0.
- R2: The external pin goes through a two-flop synchronizer. A high-to-low change on the pin sets the ext flag at the third rising edge after the change. A low-to-high change sets nothing.
- R3: A one-cycle tmr_ovf pulse sets the timer flag, and a one-cycle adc_done pulse sets the adc flag, at the edge where the pulse is sampled.
- R4: An accepted request gives call_req high for exactly one cycle in the cycle after the sampling edge. call_vec is 0x04 for ext, 0x08 for timer and 0x0C for adc.
- R5: When several requests are eligible at once, ext is taken before timer, and timer before adc.
- R6: A request is accepted only on a cycle with sample_tick high, the master enable set, its own enable set, its flag set and stack_full low.
- R7: Acceptance clears the flag of the taken source and the master enable at the same edge. Other flags are kept.
- R8: iret_strobe sets the master enable. ret_strobe does not change it. If an acceptance happens in the same cycle, the master enable is cleared.
- R9: A flag that is masked stays latched. It is taken at the first sampling cycle after its enables allow it.
- R10: A hardware flag set in the same cycle as a software write wins over the written 0.
- R11: After reset, all register bits are 0 and call_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_irq_n | input | 1 | External interrupt pin, falling-edge active |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Conversion-end pulse |
| sample_tick | input | 1 | Interrupt sampling point from the core |
| stack_full | input | 1 | Call stack has no room |
| iret_strobe | input | 1 | Return-from-interrupt executed |
| ret_strobe | input | 1 | Plain return executed |
| call_req | output | 1 | One-cycle call request |
| call_vec | output | 8 | Vector address with call_req |

## Verification
A master enable that stays set after a call shows up as a second call at the next sampling cycle, or as bit 0 reading 1 one cycle after a read. A flag that is not cleared, or is lost, shows up either as a repeated vector or as a missing vector on the next eligible sampling cycle. A wrong priority shows up on call_vec in the cycle right after the sampling edge. Errors in synchronizer latency show up as a difference of one cycle in when the ext flag is read back.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_EXT  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_ADC  = 2;
  localparam int B_GE     = 0;
  localparam int B_EN_LO  = 1;
  localparam int B_FL_LO  = B_EN_LO + NSRC;
endpackage

// File: rtl/vpic_edge_sync.sv
module vpic_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], pin};
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/vpic_ctrl_reg.sv
module vpic_ctrl_reg
  import vpic_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] acc_clr,
  input  logic            accept,
  input  logic            reti,
  output logic            ge,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] fl,
  output logic [DW-1:0]   rdata
);
  logic            hit;
  logic            ge_n;
  logic [NSRC-1:0] en_n, fl_n;

  assign hit = (addr == CTRL_ADDR);

  always_comb begin
    ge_n = ge;
    en_n = en;
    fl_n = fl;
    if (hit && wr) begin
      ge_n = wdata[B_GE];
      en_n = wdata[B_EN_LO +: NSRC];
      fl_n = wdata[B_FL_LO +: NSRC];
    end
    if (reti)   ge_n = 1'b1;
    if (accept) ge_n = 1'b0;
    fl_n = (fl_n & ~acc_clr) | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ge    <= 1'b0;
      en    <= '0;
      fl    <= '0;
      rdata <= '0;
    end else begin
      ge    <= ge_n;
      en    <= en_n;
      fl    <= fl_n;
      rdata <= '0;
      if (hit) begin
        rdata[B_GE]             <= ge;
        rdata[B_EN_LO +: NSRC]  <= en;
        rdata[B_FL_LO +: NSRC]  <= fl;
      end
    end
  end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int DW       = 8,
  parameter int VEC_STEP = 4
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [NSRC-1:0] grant,
  output logic [DW-1:0]   vec
);
  logic [NSRC:0] blocked;

  assign blocked[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_pri
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
    end
  endgenerate

  assign any = blocked[NSRC];

  always_comb begin
    vec = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (grant[k]) vec = DW'((k + 1) * VEC_STEP);
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            DW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h20,
  parameter int            VEC_STEP  = 4,
  parameter int            SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_irq_n,
  input  logic          tmr_ovf,
  input  logic          adc_done,
  input  logic          sample_tick,
  input  logic          stack_full,
  input  logic          iret_strobe,
  input  logic          ret_strobe,
  output logic          call_req,
  output logic [DW-1:0] call_vec
);
  logic            ext_fall;
  logic            glb_en;
  logic [NSRC-1:0] src_en, src_fl, grant, hw_set, acc_clr;
  logic            any_req, accept;
  logic [DW-1:0]   sel_vec;
  logic            ret_seen;

  vpic_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_irq_n), .fall(ext_fall)
  );

  assign hw_set[SRC_EXT] = ext_fall;
  assign hw_set[SRC_TMR] = tmr_ovf;
  assign hw_set[SRC_ADC] = adc_done;

  vpic_arbiter #(.DW(DW), .VEC_STEP(VEC_STEP)) u_arb (
    .req(src_en & src_fl), .any(any_req), .grant(grant), .vec(sel_vec)
  );

  assign accept  = sample_tick & glb_en & ~stack_full & any_req;
  assign acc_clr = accept ? grant : '0;

  vpic_ctrl_reg #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .hw_set(hw_set), .acc_clr(acc_clr), .accept(accept), .reti(iret_strobe),
    .ge(glb_en), .en(src_en), .fl(src_fl), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      call_req <= 1'b0;
      call_vec <= '0;
      ret_seen <= 1'b0;
    end else begin
      call_req <= accept;
      call_vec <= accept ? sel_vec : '0;
      ret_seen <= ret_strobe;
    end
  end
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          call_req,
  input logic [DW-1:0] call_vec,
  input logic [DW-1:0] rdata,
  input logic          ge,
  input logic          sample_tick,
  input logic          stack_full,
  input logic          iret_strobe
);
  p_call_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    call_req |=> !call_req);

  p_vec_legal_r4: assert property (@(posedge clk) disable iff (rst)
    call_req |-> (call_vec == 8'h04 || call_vec == 8'h08 || call_vec == 8'h0C));

  p_taken_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    call_req |-> ($past(sample_tick) && !$past(stack_full)));

  p_ge_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    call_req |-> !ge);

  p_iret_sets_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(iret_strobe) && !call_req) |-> ge);

  p_bit7_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-1] == 1'b0);
endmodule

bind vpic_top vpic_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .call_req(call_req), .call_vec(call_vec),
  .rdata(bus_rdata), .ge(glb_en), .sample_tick(sample_tick),
  .stack_full(stack_full), .iret_strobe(iret_strobe)
);

// File: tb/vpic_top_test.sv
module vpic_top_test;
  localparam logic [7:0] CA = 8'h20;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic wr = 0, pin = 1, tmr = 0, adc = 0, tick = 0, sf = 0, reti = 0, ret = 0;
  logic [7:0] rdata, vec;
  logic call;

  int errs = 0, checks = 0;

  // requirement model state
  logic       m_ge;
  logic [2:0] m_en, m_fl;
  logic       s1, s2, s3;

  always #10 clk = ~clk;

  vpic_top uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .ext_irq_n(pin), .tmr_ovf(tmr), .adc_done(adc),
    .sample_tick(tick), .stack_full(sf), .iret_strobe(reti),
    .ret_strobe(ret), .call_req(call), .call_vec(vec)
  );

  function automatic logic [7:0] vec_of(input logic [2:0] r);
    if (r[0]) return 8'h04;
    if (r[1]) return 8'h08;
    return 8'h0C;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic       acc;
    logic [2:0] req, clr, hw, fl_n;
    logic [7:0] e_rd, e_vec;
    logic       ge_n;
    req  = m_en & m_fl;
    acc  = tick & m_ge & ~sf & (|req);
    clr  = acc ? (req[0] ? 3'b001 : req[1] ? 3'b010 : 3'b100) : 3'b000;
    e_vec = acc ? vec_of(req) : 8'h00;
    e_rd = (addr == CA) ? {1'b0, m_fl, m_en, m_ge} : 8'h00;
    hw   = {adc, tmr, s3 & ~s2};
    ge_n = m_ge;
    fl_n = m_fl;
    if (wr && addr == CA) begin
      ge_n = wdata[0]; m_en = wdata[3:1]; fl_n = wdata[6:4];
    end
    if (reti) ge_n = 1'b1;
    if (acc)  ge_n = 1'b0;
    fl_n = (fl_n & ~clr) | hw;
    @(posedge clk);
    m_ge = ge_n; m_fl = fl_n;
    s3 = s2; s2 = s1; s1 = pin;
    @(negedge clk);
    check(tag, "call_req", {7'd0, call}, {7'd0, acc});
    if (acc) check(tag, "call_vec", vec, e_vec);
    check(tag, "rdata", rdata, e_rd);
    wr = 0; tmr = 0; adc = 0; tick = 0; reti = 0; ret = 0;
  endtask

  task automatic wreg(input logic [7:0] v, input string tag);
    addr = CA; wr = 1; wdata = v; step(tag);
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    m_ge = 0; m_en = 0; m_fl = 0; s1 = 1; s2 = 1; s3 = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    addr = CA;
    step("R11");
    step("R11");
    // R1 layout, bit 7 stays 0
    wreg(8'hFF, "R1"); step("R1");
    wreg(8'h00, "R1"); step("R1");
    addr = 8'h21; step("R1"); addr = CA;
    // R2 falling edge after synchronizer
    pin = 0;
    for (int i = 0; i < 4; i++) step("R2");
    wreg(8'h00, "R2");
    pin = 1;
    for (int i = 0; i < 4; i++) step("R2");
    // R3 timer and adc pulses
    tmr = 1; step("R3"); step("R3");
    adc = 1; step("R3"); step("R3");
    // R5 priority, R7 clearing, R8 iret
    wreg(8'h7F, "R5");
    tick = 1; step("R5"); step("R7");
    ret = 1; step("R8"); step("R8");
    reti = 1; step("R8");
    tick = 1; step("R5"); step("R7");
    reti = 1; step("R8");
    tick = 1; step("R5"); step("R4");
    // R6 blocking conditions
    wreg(8'h7F, "R6");
    sf = 1; tick = 1; step("R6"); sf = 0;
    wreg(8'h7E, "R6"); tick = 1; step("R6");
    wreg(8'h7F, "R6"); step("R6"); step("R6");
    // R9 masked request stays latched
    wreg(8'h1D, "R9"); tick = 1; step("R9");
    tick = 1; step("R9");
    wreg(8'h1F, "R9"); tick = 1; step("R9"); step("R9");
    // R10 hardware set beats software clear
    tmr = 1; wreg(8'h00, "R10"); step("R10");
    adc = 1; wreg(8'h0E, "R10"); step("R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      addr  = r[0] ? CA : {r[7:1], 1'b1};
      wr    = (r[10:8] == 3'd0);
      wdata = {1'b0, r[17:11]};
      tmr   = (r[20:18] == 3'd0);
      adc   = (r[23:21] == 3'd0);
      tick  = r[24];
      sf    = (r[26:25] == 2'd0);
      reti  = (r[28:27] == 2'd0);
      ret   = r[29];
      if (r[31:30] == 2'd0) pin = ~pin;
      step("R6");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule